// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single register accesses on the two-wire PHY management pair. The host presents a request carrying a 5-bit PHY address, a 5-bit register number, a read/write flag and 16 bits of write data. The block serialises the whole frame on the management clock and data lines. It controls the output enable of the bidirectional data pin and samples the PHY's reply. It reports completion with a one-cycle done pulse, and a read result is left on a holding register.

The management clock is derived from the system clock by a parameterised phase timer, so that each low and each high phase lasts exactly `HALF_CYC` system cycles. A frame element is presented at the start of the low phase. The clock then rises, and the data line is sampled in the last cycle of the high phase. Read frames are 64 elements long and write frames are 65. In both kinds the last element is released and not driven.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset, mdc, mdo, mdo_en, busy and done are all 0, and rd_data is 0.
- R2: Every frame opens with 32 elements in which mdo_en=1 and mdo=1.
- R3: Elements 32..35 are driven with mdo_en=1. They carry the start pair 0,1, then the opcode: 1,0 for a read (req_write=0) or 0,1 for a write (req_write=1).
- R4: Elements 36..40 carry req_phy and elements 41..45 carry req_reg, each most significant bit first, with mdo_en=1.
- R5: A read frame releases mdo_en for one turnaround element (46). It captures mdi in elements 47..62 as rd_data[15] down to rd_data[0], then ends with one released element (63), for 64 mdc pulses in total.
- R6: A write frame releases mdo_en with mdo=0 for elements 46..47. It drives req_wdata[15] down to req_wdata[0] in elements 48..63 with mdo_en=1, then ends with one released element (64), for 65 mdc pulses in total.
- R7: Each mdc low phase and each mdc high phase lasts HALF_CYC clk cycles, and mdo and mdo_en do not change while mdc is high. A frame therefore keeps busy high for (pulses x 2 x HALF_CYC) cycles.
- R8: A request is accepted when req_valid=1 and busy=0. busy is high from the next cycle until the frame ends, and req_valid is ignored while busy is high.
- R9: done is high for exactly one cycle, in the first cycle after the frame with busy low. rd_data changes only in that cycle after a read, and a write frame leaves rd_data unchanged.
- R10: Outside a frame, mdc, mdo and mdo_en are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write frame, 0 = read frame |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register number |
| req_wdata | input | 16 | Data for a write frame |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 16 | Last read result, held |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Data out toward the PHY |
| mdo_en | output | 1 | Output enable of the data pin |
| mdi | input | 1 | Data in from the PHY |

## Verification
The bench builds the block with HALF_CYC=2. At that setting low and high phases are more than one cycle long, so a timer that ends a phase early or late shows up in the measured busy length and in the high-phase assertion. Complete 64- and 65-pulse frames also finish in a few hundred cycles, which leaves room for reads and writes with distinct address, register and data patterns. With a PHY model answering on mdi, the bench covers both turnaround shapes, the final released element, and a request issued in the middle of a frame.

// File: rtl/mdio_frame_pkg.sv
package mdio_frame_pkg;

  localparam int FRAME_W  = 65;   // longest frame, in elements
  localparam int HDR_LEN  = 46;   // preamble + start + opcode + address + register
  localparam int RD_LEN   = 64;
  localparam int WR_LEN   = 65;
  localparam int RD_FIRST = 47;   // first element holding PHY data on a read
  localparam int RD_LAST  = 62;
  localparam int DATA_W   = 16;
  localparam int IDX_W    = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} mdio_state_t;

  // Data value of each element, element 0 in the MSB
  function automatic logic [FRAME_W-1:0] frame_data(input logic wr,
                                                    input logic [4:0] phy,
                                                    input logic [4:0] regn,
                                                    input logic [DATA_W-1:0] wd);
    logic [18:0] tail;
    tail = wr ? {2'b00, wd, 1'b0} : 19'd0;
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, regn, tail};
  endfunction

  // Output enable of each element, element 0 in the MSB
  function automatic logic [FRAME_W-1:0] frame_oe(input logic wr);
    logic [18:0] tail;
    tail = wr ? {2'b00, {DATA_W{1'b1}}, 1'b0} : 19'd0;
    return {{HDR_LEN{1'b1}}, tail};
  endfunction

  function automatic logic [IDX_W-1:0] frame_last(input logic wr);
    return wr ? IDX_W'(WR_LEN - 1) : IDX_W'(RD_LEN - 1);
  endfunction

endpackage

// File: rtl/mdio_phase_timer.sv
module mdio_phase_timer #(
  parameter int HALF_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic phase_end
);
  localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HALF_CYC - 1);

  logic [CNT_W-1:0] cnt;

  assign phase_end = run && (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || phase_end) cnt <= '0;
    else                             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [4:0]        req_phy,
  input  logic [4:0]        req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              phase_end,
  input  logic              mdi,
  output logic              busy,
  output logic              in_high,
  output logic              bit_d,
  output logic              bit_oe,
  output logic              accept,
  output logic              frame_end,
  output logic              done,
  output logic [DATA_W-1:0] rd_data
);
  mdio_state_t        state;
  logic [FRAME_W-1:0] dvec, oevec;
  logic [IDX_W-1:0]   idx, last_idx;
  logic               is_wr;
  logic [DATA_W-1:0]  cap;
  logic               sample_now, in_window;
  logic [IDX_W-1:0]   pos;

  assign busy       = (state != ST_IDLE);
  assign in_high    = (state == ST_HIGH);
  assign accept     = (state == ST_IDLE) && req_valid;
  assign sample_now = in_high && phase_end;
  assign frame_end  = sample_now && (idx == last_idx);
  assign in_window  = !is_wr && (idx >= IDX_W'(RD_FIRST)) && (idx <= IDX_W'(RD_LAST));
  assign pos        = IDX_W'(FRAME_W - 1) - idx;
  assign bit_d      = busy && dvec[pos];
  assign bit_oe     = busy && oevec[pos];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      dvec     <= '0;
      oevec    <= '0;
      idx      <= '0;
      last_idx <= '0;
      is_wr    <= 1'b0;
      cap      <= '0;
      rd_data  <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          dvec     <= frame_data(req_write, req_phy, req_reg, req_wdata);
          oevec    <= frame_oe(req_write);
          is_wr    <= req_write;
          last_idx <= frame_last(req_write);
          idx      <= '0;
          state    <= ST_LOW;
        end
        ST_LOW: if (phase_end) state <= ST_HIGH;
        ST_HIGH: if (phase_end) begin
          if (in_window) cap <= {cap[DATA_W-2:0], mdi};
          if (idx == last_idx) begin
            state <= ST_IDLE;
            done  <= 1'b1;
            if (!is_wr) rd_data <= cap;
          end else begin
            idx   <= idx + 1'b1;
            state <= ST_LOW;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master #(
  parameter int HALF_CYC = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        mdc,
  output logic        mdo,
  output logic        mdo_en,
  input  logic        mdi
);
  logic phase_end, in_high, bit_d, bit_oe, accept, frame_end;

  mdio_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .phase_end (phase_end)
  );

  mdio_frame_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_phy   (req_phy),
    .req_reg   (req_reg),
    .req_wdata (req_wdata),
    .phase_end (phase_end),
    .mdi       (mdi),
    .busy      (busy),
    .in_high   (in_high),
    .bit_d     (bit_d),
    .bit_oe    (bit_oe),
    .accept    (accept),
    .frame_end (frame_end),
    .done      (done),
    .rd_data   (rd_data)
  );

  assign mdc    = in_high;
  assign mdo    = bit_d;
  assign mdo_en = bit_oe;
endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk #(
  parameter int HALF_CYC = 10
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic [15:0] rd_data,
  input logic        mdc,
  input logic        mdo,
  input logic        mdo_en,
  input logic        accept,
  input logic        frame_end
);
  logic [15:0] hi_run;

  always_ff @(posedge clk) begin
    if (!rst_n || !mdc)      hi_run <= '0;
    else if (hi_run != '1)   hi_run <= hi_run + 1'b1;
  end

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_end) |=> busy);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (done && !busy));
  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> done);
  // R7
  mdo_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> ($stable(mdo) && $stable(mdo_en)));
  // R7
  high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdc) |-> (hi_run == 16'(HALF_CYC)));
  // R10
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdo && !mdo_en));
endmodule

bind mdio_frame_master mdio_frame_master_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .rd_data   (rd_data),
  .mdc       (mdc),
  .mdo       (mdo),
  .mdo_en    (mdo_en),
  .accept    (accept),
  .frame_end (frame_end)
);

// File: tb/mdio_frame_master_bench.sv
`timescale 1ns/1ps
module mdio_frame_master_bench;
  localparam int H = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [4:0] req_phy = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic busy, done, mdc, mdo, mdo_en;
  logic mdi = 1'b1;
  logic [15:0] rd_data;

  always #2.5 clk = ~clk;

  mdio_frame_master #(.HALF_CYC(H)) u_mdio_frame_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data),
    .mdc(mdc), .mdo(mdo), .mdo_en(mdo_en), .mdi(mdi)
  );

  int n_checks = 0, n_fail = 0;
  int cyc = 0, busy_cyc = 0, done_cyc = 0, n_rise = 0;
  bit timed_out = 0;
  logic rec_d [0:79];
  logic rec_oe[0:79];
  logic exp_d [0:79];
  logic exp_oe[0:79];
  int   exp_n;
  logic [15:0] phy_pat = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (busy) busy_cyc <= busy_cyc + 1;
    if (done) done_cyc <= done_cyc + 1;
  end

  // PHY model: record each element at the rising clock, answer on the falling one
  always @(posedge mdc) begin
    if (n_rise < 80) begin
      rec_d[n_rise]  = mdo;
      rec_oe[n_rise] = mdo_en;
    end
    n_rise = n_rise + 1;
  end
  always @(negedge mdc) begin
    if (n_rise >= 47 && n_rise <= 62) mdi = phy_pat[15 - (n_rise - 47)];
    else                              mdi = 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic d, input logic oe);
    exp_d[exp_n]  = d;
    exp_oe[exp_n] = oe;
    exp_n++;
  endtask

  task automatic build_expect(input logic wr, input logic [4:0] phy,
                              input logic [4:0] rg, input logic [15:0] wd);
    exp_n = 0;
    for (int i = 0; i < 32; i++) push(1'b1, 1'b1);
    push(1'b0, 1'b1); push(1'b1, 1'b1);
    push(!wr, 1'b1);  push(wr, 1'b1);
    for (int i = 4; i >= 0; i--) push(phy[i], 1'b1);
    for (int i = 4; i >= 0; i--) push(rg[i], 1'b1);
    if (wr) begin
      push(1'b0, 1'b0); push(1'b0, 1'b0);
      for (int i = 15; i >= 0; i--) push(wd[i], 1'b1);
    end else begin
      push(1'b0, 1'b0);
      for (int i = 0; i < 16; i++) push(1'b0, 1'b0);
    end
    push(1'b0, 1'b0);
  endtask

  // compare elements lo..hi of one frame, returns mismatch count
  function automatic int cmp_range(input int lo, input int hi);
    int bad = 0;
    for (int i = lo; i <= hi; i++)
      if (rec_d[i] !== exp_d[i] || rec_oe[i] !== exp_oe[i]) bad++;
    return bad;
  endfunction

  task automatic start_req(input logic wr, input logic [4:0] phy,
                           input logic [4:0] rg, input logic [15:0] wd, input int hold);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_phy = phy; req_reg = rg; req_wdata = wd;
    repeat (hold) @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!done && !timed_out) @(negedge clk);
  endtask

  task automatic clear_rec();
    @(negedge clk);
    n_rise = 0; busy_cyc = 0; done_cyc = 0;
  endtask

  task automatic frame_checks(input logic wr, input logic [15:0] exp_rd);
    int bad;
    check(n_rise == exp_n, wr ? "R6 pulse count" : "R5 pulse count", n_rise, exp_n);
    bad = cmp_range(0, 31);  check(bad == 0, "R2 preamble", bad, 0);
    bad = cmp_range(32, 35); check(bad == 0, "R3 start/opcode", bad, 0);
    bad = cmp_range(36, 45); check(bad == 0, "R4 address/register", bad, 0);
    bad = cmp_range(46, exp_n - 1);
    check(bad == 0, wr ? "R6 turnaround/data/tail" : "R5 turnaround/tail", bad, 0);
    check(busy_cyc == exp_n * 2 * H, "R7 frame length", busy_cyc, exp_n * 2 * H);
    check(!busy, "R9 busy low with done", busy, 0);
    check(rd_data == exp_rd, "R9 rd_data", rd_data, exp_rd);
    check(!mdc && !mdo && !mdo_en, "R10 idle lines", {mdc, mdo, mdo_en}, 0);
    @(negedge clk);
    check(done_cyc == 1, "R9 done width", done_cyc, 1);
  endtask

  task automatic t_reset();
    check(!mdc && !mdo && !mdo_en, "R1 lines", {mdc, mdo, mdo_en}, 0);
    check(!busy && !done, "R1 busy/done", {busy, done}, 0);
    check(rd_data == 16'h0, "R1 rd_data", rd_data, 0);
  endtask

  task automatic t_read(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] pat);
    clear_rec();
    phy_pat = pat;
    build_expect(1'b0, phy, rg, 16'h0);
    start_req(1'b0, phy, rg, 16'hFFFF, 1);
    wait_done();
    frame_checks(1'b0, pat);
  endtask

  task automatic t_write(input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] wd, input logic [15:0] keep);
    clear_rec();
    phy_pat = 16'h0;
    build_expect(1'b1, phy, rg, wd);
    start_req(1'b1, phy, rg, wd, 1);
    wait_done();
    frame_checks(1'b1, keep);  // R9: write leaves rd_data alone
  endtask

  task automatic t_ignore_busy();
    clear_rec();
    phy_pat = 16'h5AC3;
    build_expect(1'b0, 5'h0A, 5'h15, 16'h0);
    start_req(1'b0, 5'h0A, 5'h15, 16'h0, 1);
    repeat (30) @(negedge clk);
    start_req(1'b1, 5'h1F, 5'h00, 16'hFFFF, 4);   // R8: must be ignored
    wait_done();
    frame_checks(1'b0, 16'h5AC3);
    repeat (10) @(negedge clk);
    check(!busy && n_rise == exp_n, "R8 no second frame", n_rise, exp_n);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_read(5'h11, 5'h02, 16'hA5C3);
    t_write(5'h03, 5'h1C, 16'h8001, 16'hA5C3);
    t_read(5'h1F, 5'h1F, 16'hFFFF);
    t_write(5'h00, 5'h00, 16'h7E5A, 16'hFFFF);
    t_read(5'h00, 5'h00, 16'h0000);
    t_ignore_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    timed_out = 1;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule